// File: doc/BRIEF.md
# Paged RAM Mapper with Reserved Firmware Pages

The block places physical RAM behind the 64 KB CPU address space. It splits that space into four 16 KB segments, and each segment has a page register that names the physical 16 KB page it shows. Software loads a page register with an I/O write. Every CPU access is then turned into a physical RAM address made of that page number and the 14-bit offset within the segment. The physical RAM sits outside the block and answers a read one cycle after it is enabled.

A firmware-source select input (`fw_rom_sel`) picks between two firmware modes. When it is 1, firmware comes from ROM. In that mode every physical page is ordinary RAM, and the mapper does not serve firmware-region fetches. When it is 0, firmware runs from a copy held in RAM. In that mode the four highest physical pages hold the firmware image and are hidden from normal mapped access: reads of them return 0xFF and writes to them are dropped. Firmware-region fetches in that mode go read-only into those four pages, firmware segment k to reserved page k.

Because the reserved pages are out of reach in RAM-copy mode, the firmware image has to be written while the block is still in ROM mode. Software does this by mapping the top pages into a segment and writing them with ordinary accesses.

Top module: `hfw_mapper`

## Requirements
- R1: After reset, segment s maps to physical page s, `ram_en` is 0 and `cpu_rvalid` is 0.
- R2: An `io_wr` to I/O address 0xFC+s (s = 0..3) loads segment s's page register with the low log2(PAGES) bits of `io_wdata`, and the upper data bits are ignored. A write to any other I/O address changes no mapping.
- R3: A normal access (`cpu_fw`=0) to an unreserved page asserts `ram_en` in the same cycle, with `ram_addr` = {page register of segment `cpu_addr[15:14]`, `cpu_addr[13:0]`}, `ram_we` = `cpu_we` and `ram_wdata` = `cpu_wdata`.
- R4: A read that the block serves raises `cpu_rvalid` for one cycle, in the cycle after the request. `cpu_rdata` then carries the RAM data, or 0xFF for a hidden page.
- R5: With `fw_rom_sel`=0, a normal write to one of the pages PAGES-4..PAGES-1 leaves `ram_en` low, so RAM content does not change.
- R6: With `fw_rom_sel`=0, a normal read of one of the pages PAGES-4..PAGES-1 does not enable RAM and returns 0xFF.
- R7: With `fw_rom_sel`=1, the pages PAGES-4..PAGES-1 are read and written like any other page.
- R8: With `fw_rom_sel`=0, a firmware read (`cpu_fw`=1) in segment k accesses physical page PAGES-4+k at the same offset and returns its data.
- R9: With `fw_rom_sel`=0, a firmware write is dropped: `ram_en` stays low.
- R10: With `fw_rom_sel`=1, a firmware access neither enables RAM nor produces `cpu_rvalid`.
- R11: A page register write takes effect from the next cycle. A CPU access in the same cycle as the write uses the old mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O address |
| io_wdata | input | 8 | I/O write data |
| fw_rom_sel | input | 1 | 1 = firmware from ROM, 0 = firmware from RAM copy |
| cpu_req | input | 1 | CPU access request, one cycle per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_fw | input | 1 | 1 = firmware-region access |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | 8 | Read data |
| ram_en | output | 1 | Physical RAM enable |
| ram_we | output | 1 | Physical RAM write enable |
| ram_addr | output | log2(PAGES)+14 | Physical RAM byte address |
| ram_wdata | output | 8 | Physical RAM write data |
| ram_rdata | input | 8 | Physical RAM read data, one cycle after `ram_en` |

## Verification
The bench builds the mapper with PAGES=8, so the reserved pages are 4 to 7 and the page field is 3 bits wide. With that setting, a page-register write of 0x0D lands on page 5, which checks that the upper data bits are dropped. Four page-register loads are enough to fill the whole firmware area in ROM mode. The bench then switches to RAM-copy mode and reads the image back through firmware fetches. After returning to ROM mode it reads the pages again to prove that the masked and firmware writes left them unchanged. The same-cycle case of a page write and an access is driven on purpose.

// File: rtl/hfw_mapper_pkg.sv
// Package: hfw_mapper_pkg
// Shared types of the paged mapper. It assumes a 16-bit CPU address
// split into segment bits on top and offset bits below.
package hfw_mapper_pkg;

    // How one CPU access is handled by the translator.
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,  // nothing reaches RAM, no read data
        ACC_RAM    = 2'd1,  // passed to physical RAM
        ACC_HIDDEN = 2'd2,  // read of a hidden page, answered with all ones
        ACC_DROP   = 2'd3   // write that is discarded
    } acc_kind_e;

endpackage

// File: rtl/hfw_page_regs.sv
// Module: hfw_page_regs
// Holds one page register per CPU segment. Each register is loaded by an
// I/O write to its own address, IO_BASE + segment index. Only the low
// PAGE_W data bits are stored. Assumes the I/O addresses of the segments
// do not overlap with anything else decoded on this bus.
module hfw_page_regs #(
    parameter int SEGS    = 4,
    parameter int PAGE_W  = 5,
    parameter int IO_BASE = 252
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          io_wr,
    input  logic [7:0]                    io_addr,
    input  logic [PAGE_W-1:0]             io_page,
    output logic [SEGS-1:0][PAGE_W-1:0]   pages
);

    for (genvar s = 0; s < SEGS; s++) begin : g_seg
        logic hit;
        assign hit = io_wr && (io_addr == 8'(IO_BASE + s));

        // Load this segment's page number; reset maps segment s to page s.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pages[s] <= PAGE_W'(s);
            else if (hit)
                pages[s] <= io_page;
        end
    end

endmodule

// File: rtl/hfw_xlate.sv
// Module: hfw_xlate
// Combinational translation of one CPU access into a physical RAM access.
// It decides whether the access reaches RAM, is hidden, is dropped or is
// ignored, based on the firmware-source mode. Assumes one access per cycle
// and that the reserved firmware pages number exactly one per segment.
module hfw_xlate
    import hfw_mapper_pkg::*;
#(
    parameter int PAGES  = 32,
    parameter int RSV    = 4,
    parameter int SEGS   = 4,
    parameter int SEG_W  = 2,
    parameter int OFFS_W = 14,
    parameter int PAGE_W = 5
) (
    input  logic                          cpu_req,
    input  logic                          cpu_we,
    input  logic                          cpu_fw,
    input  logic [SEG_W+OFFS_W-1:0]       cpu_addr,
    input  logic                          fw_rom_sel,
    input  logic [SEGS-1:0][PAGE_W-1:0]   pages,
    output acc_kind_e                     kind,
    output logic [PAGE_W+OFFS_W-1:0]      phys_addr
);

    localparam int FW_BASE = PAGES - RSV;

    logic [SEG_W-1:0]  seg;
    logic [PAGE_W-1:0] map_page;
    logic [PAGE_W-1:0] fw_page;
    logic [PAGE_W-1:0] sel_page;
    logic              reserved;
    logic              copy_mode;

    assign seg       = cpu_addr[SEG_W+OFFS_W-1:OFFS_W];
    assign map_page  = pages[seg];
    assign fw_page   = PAGE_W'(FW_BASE) + PAGE_W'(seg);
    assign copy_mode = !fw_rom_sel;
    assign reserved  = copy_mode && (map_page >= PAGE_W'(FW_BASE));
    assign sel_page  = cpu_fw ? fw_page : map_page;
    assign phys_addr = {sel_page, cpu_addr[OFFS_W-1:0]};

    // Classify the access by mode, region and direction.
    always_comb begin
        kind = ACC_NONE;
        if (cpu_req) begin
            if (cpu_fw) begin
                if (copy_mode)
                    kind = cpu_we ? ACC_DROP : ACC_RAM;
                else
                    kind = ACC_NONE;
            end else if (reserved) begin
                kind = cpu_we ? ACC_DROP : ACC_HIDDEN;
            end else begin
                kind = ACC_RAM;
            end
        end
    end

endmodule

// File: rtl/hfw_rd_ret.sv
// Module: hfw_rd_ret
// Read return path. It registers whether a read was issued and whether that
// read was hidden. In the following cycle it presents either the RAM data
// or all ones. Assumes the RAM returns data exactly one cycle after enable.
module hfw_rd_ret #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_ram,
    input  logic              rd_hidden,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata
);

    logic hidden_q;

    // Track the read issued in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_rvalid <= 1'b0;
            hidden_q   <= 1'b0;
        end else begin
            cpu_rvalid <= rd_ram || rd_hidden;
            hidden_q   <= rd_hidden;
        end
    end

    // Choose the returned byte: hidden pages read as all ones.
    always_comb begin
        if (!cpu_rvalid)
            cpu_rdata = '0;
        else if (hidden_q)
            cpu_rdata = '1;
        else
            cpu_rdata = ram_rdata;
    end

endmodule

// File: rtl/hfw_mapper.sv
// Module: hfw_mapper (top)
// Paged RAM mapper with four 16 KB segments. In RAM-copy firmware mode the
// top RSV physical pages are hidden from normal access and serve firmware
// fetches read-only. Assumes a single-cycle CPU request and an external RAM
// with one cycle of read latency. Filling the firmware pages is left to
// software running in ROM mode.
module hfw_mapper
    import hfw_mapper_pkg::*;
#(
    parameter int PAGES   = 32,
    parameter int RSV     = 4,
    parameter int OFFS_W  = 14,
    parameter int IO_BASE = 252,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    localparam int PAGE_W = $clog2(PAGES),
    localparam int PHYS_W = PAGE_W + OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic [7:0]        io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              fw_rom_sel,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_fw,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [PHYS_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);

    localparam int SEG_W = ADDR_W - OFFS_W;
    localparam int SEGS  = 1 << SEG_W;

    logic [SEGS-1:0][PAGE_W-1:0] pages;
    acc_kind_e                   kind;
    logic                        unused_io_bits;

    assign unused_io_bits = ^io_wdata;

    hfw_page_regs #(
        .SEGS    (SEGS),
        .PAGE_W  (PAGE_W),
        .IO_BASE (IO_BASE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_wr   (io_wr),
        .io_addr (io_addr),
        .io_page (io_wdata[PAGE_W-1:0]),
        .pages   (pages)
    );

    hfw_xlate #(
        .PAGES  (PAGES),
        .RSV    (RSV),
        .SEGS   (SEGS),
        .SEG_W  (SEG_W),
        .OFFS_W (OFFS_W),
        .PAGE_W (PAGE_W)
    ) u_xlate (
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_fw     (cpu_fw),
        .cpu_addr   (cpu_addr),
        .fw_rom_sel (fw_rom_sel),
        .pages      (pages),
        .kind       (kind),
        .phys_addr  (ram_addr)
    );

    assign ram_en    = (kind == ACC_RAM);
    assign ram_we    = ram_en && cpu_we;
    assign ram_wdata = cpu_wdata;

    hfw_rd_ret #(
        .DATA_W (DATA_W)
    ) u_ret (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_ram     (ram_en && !cpu_we),
        .rd_hidden  (kind == ACC_HIDDEN),
        .ram_rdata  (ram_rdata),
        .cpu_rvalid (cpu_rvalid),
        .cpu_rdata  (cpu_rdata)
    );

endmodule

// File: rtl/hfw_mapper_chk.sv
// Module: hfw_mapper_chk
// Property checker for hfw_mapper, attached with bind. It watches the
// ports only and relates the mode and access inputs to the RAM and
// read-return outputs.
module hfw_mapper_chk #(
    parameter int PAGES  = 32,
    parameter int RSV    = 4,
    parameter int PAGE_W = 5,
    parameter int PHYS_W = 19,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fw_rom_sel,
    input logic              cpu_req,
    input logic              cpu_we,
    input logic              cpu_fw,
    input logic              cpu_rvalid,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              ram_en,
    input logic              ram_we,
    input logic [PHYS_W-1:0] ram_addr
);

    logic [PAGE_W-1:0] ram_page;
    assign ram_page = ram_addr[PHYS_W-1 -: PAGE_W];

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !cpu_rvalid);

    // R3
    idle_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_req |-> !ram_en);

    // R4
    read_returns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !ram_we) |=> cpu_rvalid);

    // R4
    rvalid_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> $past(cpu_req && !cpu_we));

    // R5
    normal_not_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && !cpu_fw && !fw_rom_sel) |-> (ram_page < PAGE_W'(PAGES - RSV)));

    // R8
    fw_in_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && cpu_fw) |-> (ram_page >= PAGE_W'(PAGES - RSV)));

    // R9
    fw_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_fw && cpu_we) |-> !ram_en);

    // R10
    rom_fw_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_fw && fw_rom_sel) |-> !ram_en);

    // R10
    rom_fw_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_fw && fw_rom_sel) |=> !cpu_rvalid);

    // R6
    hidden_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && !cpu_fw && !fw_rom_sel && !ram_en) |=>
            (cpu_rvalid && cpu_rdata == '1));

endmodule

bind hfw_mapper hfw_mapper_chk #(
    .PAGES  (PAGES),
    .RSV    (RSV),
    .PAGE_W (PAGE_W),
    .PHYS_W (PHYS_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fw_rom_sel (fw_rom_sel),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_fw     (cpu_fw),
    .cpu_rvalid (cpu_rvalid),
    .cpu_rdata  (cpu_rdata),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr)
);

// File: tb/test_hfw_mapper.sv
`timescale 1ns/1ps
module test_hfw_mapper;

    localparam int PAGES  = 8;
    localparam int PAGE_W = 3;
    localparam int PHYS_W = PAGE_W + 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              io_wr = 1'b0;
    logic [7:0]        io_addr = '0;
    logic [7:0]        io_wdata = '0;
    logic              fw_rom_sel = 1'b1;
    logic              cpu_req = 1'b0;
    logic              cpu_we = 1'b0;
    logic              cpu_fw = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic [7:0]        cpu_wdata = '0;
    logic              cpu_rvalid;
    logic [7:0]        cpu_rdata;
    logic              ram_en;
    logic              ram_we;
    logic [PHYS_W-1:0] ram_addr;
    logic [7:0]        ram_wdata;
    logic [7:0]        ram_rdata = '0;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] mem[int];

    always #2.5 clk = ~clk;

    hfw_mapper #(.PAGES(PAGES)) i_hfw_mapper (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .fw_rom_sel(fw_rom_sel), .cpu_req(cpu_req),
        .cpu_we(cpu_we), .cpu_fw(cpu_fw), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    // Physical RAM model with one cycle of read latency.
    always @(posedge clk) begin
        if (ram_en) begin
            if (ram_we)
                mem[int'(ram_addr)] = ram_wdata;
            else
                ram_rdata <= mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 8'h00;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected read data when the design returns a read.
    always @(negedge clk) begin
        if (rst_n && cpu_rvalid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R4 unexpected cpu_rvalid", 1, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(cpu_rdata == e, t, cpu_rdata, e);
            end
        end
    end

    // Driver: one single-cycle access with its expected RAM side and data.
    task automatic acc(input bit we, input bit fw, input logic [15:0] a,
                       input logic [7:0] d, input bit exp_en,
                       input logic [PAGE_W-1:0] exp_pg, input bit exp_rd,
                       input logic [7:0] exp_d, input string tag);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_fw = fw; cpu_addr = a; cpu_wdata = d;
        #1;
        check(ram_en == exp_en, {tag, " ram_en"}, ram_en, exp_en);
        if (exp_en) begin
            check(ram_addr == {exp_pg, a[13:0]}, {tag, " ram_addr"},
                  ram_addr, {exp_pg, a[13:0]});
            check(ram_we == we, {tag, " ram_we"}, ram_we, we);
        end
        if (exp_rd) begin
            exp_q.push_back(exp_d);
            tag_q.push_back({tag, " rdata"});
        end
        @(negedge clk);
        cpu_req = 1'b0;
        #1;
        if (!exp_rd)
            check(cpu_rvalid == 1'b0, {tag, " no rvalid"}, cpu_rvalid, 0);
    endtask

    task automatic set_page(input logic [7:0] ioa, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = ioa; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(ram_en == 1'b0, "R1 reset ram_en", ram_en, 0);
        check(cpu_rvalid == 1'b0, "R1 reset cpu_rvalid", cpu_rvalid, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // ROM mode: default mapping and ordinary pages.
        acc(1, 0, 16'h0005, 8'h11, 1, 3'd0, 0, 0, "R1 R3 seg0 write");
        acc(0, 0, 16'h0005, 8'h00, 1, 3'd0, 1, 8'h11, "R4 seg0 read");
        acc(0, 0, 16'hC123, 8'h00, 1, 3'd3, 1, 8'h00, "R1 seg3 default page");

        // R2: upper bits dropped, 0x0D selects page 5 (reserved, but ROM mode).
        set_page(8'hFE, 8'h0D);
        acc(1, 0, 16'h8010, 8'h5A, 1, 3'd5, 0, 0, "R2 R7 seg2 page5 write");
        acc(0, 0, 16'h8010, 8'h00, 1, 3'd5, 1, 8'h5A, "R7 seg2 page5 read");

        // R2: non-register address has no effect.
        set_page(8'hFB, 8'h01);
        acc(0, 0, 16'hC123, 8'h00, 1, 3'd3, 1, 8'h00, "R2 ignored io addr");

        // R7: fill firmware pages 4..7 while in ROM mode.
        for (int k = 0; k < 4; k++) begin
            set_page(8'hFE, 8'(4 + k));
            acc(1, 0, 16'h8020, 8'(8'hA0 + k), 1, 3'(4 + k), 0, 0, "R7 fill");
        end

        // RAM-copy mode.
        @(negedge clk);
        fw_rom_sel = 1'b0;
        acc(0, 0, 16'h8020, 8'h00, 0, 3'd0, 1, 8'hFF, "R6 hidden read");
        acc(1, 0, 16'h8020, 8'h33, 0, 3'd0, 0, 0, "R5 hidden write");
        for (int k = 0; k < 4; k++)
            acc(0, 1, {2'(k), 14'h0020}, 8'h00, 1, 3'(4 + k), 1,
                8'(8'hA0 + k), "R8 fw read");
        acc(1, 1, 16'h4020, 8'h77, 0, 3'd0, 0, 0, "R9 fw write");
        acc(0, 0, 16'h0005, 8'h00, 1, 3'd0, 1, 8'h11, "R3 copy mode normal page");

        // Back to ROM mode.
        @(negedge clk);
        fw_rom_sel = 1'b1;
        acc(0, 1, 16'h0020, 8'h00, 0, 3'd0, 0, 0, "R10 rom fw read");
        acc(0, 0, 16'h8020, 8'h00, 1, 3'd7, 1, 8'hA3, "R5 page7 unchanged");
        set_page(8'hFE, 8'h05);
        acc(0, 0, 16'h8020, 8'h00, 1, 3'd5, 1, 8'hA1, "R9 page5 unchanged");

        // R11: page write and access in the same cycle.
        @(negedge clk);
        io_wr = 1'b1; io_addr = 8'hFD; io_wdata = 8'h06;
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_fw = 1'b0;
        cpu_addr = 16'h4040; cpu_wdata = 8'h66;
        #1;
        check(ram_en == 1'b1, "R11 same-cycle ram_en", ram_en, 1);
        check(ram_addr == {3'd1, 14'h0040}, "R11 same-cycle old page",
              ram_addr, {3'd1, 14'h0040});
        @(negedge clk);
        io_wr = 1'b0; cpu_req = 1'b0;
        acc(0, 0, 16'h4040, 8'h00, 1, 3'd6, 1, 8'h00, "R11 new page next");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 reads outstanding", exp_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule